// File: doc/BRIEF.md
# Wiper Position Register

This block holds the 8-bit position of one channel of a digitally controlled potentiometer and turns that position into a one-hot select for a 256-tap resistor array. A command layer above it decodes the serial protocol and hands it single-cycle strobes. A write strobe loads a host byte. A transfer strobe copies one of the channel's four stored bytes. A step command starts a stepping window in which every rising edge of the serial clock moves the wiper by one tap, and the serial data line sets the direction of each move.

Reset recalls stored slot zero into the register. The same slot is recalled again on any later reset. Stepping saturates at both ends of the array. The tap select is a registered decode of the position, so it follows any change of the position one clock later.

Top module: `wiper_pos_reg`

## Requirements
- R1: While `rst` is high, at every clock edge `pos` is loaded with stored slot 0 (`bank[7:0]`). The recalled value is present on the first cycle after reset is released, and stepping is disarmed by reset.
- R2: A cycle with `wr_stb` high loads `wr_data` into `pos` at that clock edge.
- R3: A cycle with `xfer_stb` high loads stored slot `xfer_sel` (`bank[8*xfer_sel +: 8]`, slot 0 in the lowest byte) into `pos` at that clock edge.
- R4: The loads have a fixed priority: reset first, then write, then transfer, then step.
- R5: While stepping is armed, each low-to-high transition of `ser_clk` moves `pos` by one step at the clock edge where `ser_clk` is first sampled high. The move is +1 when `ser_din` is 1 and -1 when it is 0. Holding `ser_clk` high gives only one step.
- R6: Stepping saturates. An up step at 0xFF and a down step at 0x00 leave `pos` unchanged, and it never wraps.
- R7: A `step_arm` strobe arms stepping for the clock cycles that follow it. `txn_end` disarms it, and `txn_end` wins when both are high in the same cycle. Edges of `ser_clk` while stepping is disarmed, or in a cycle with `txn_end` high, leave `pos` unchanged.
- R8: `tap_sel` has exactly one bit set, bit n for position n, so bit 0 is the tap nearest the low terminal and bit 255 the tap nearest the high terminal. It shows the value `pos` held one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; recalls slot 0 |
| bank | input | 32 | Four stored bytes of the channel, slot 0 in bits 7:0 |
| wr_stb | input | 1 | Single-cycle direct write strobe |
| wr_data | input | 8 | Host byte for a direct write |
| xfer_stb | input | 1 | Single-cycle transfer strobe |
| xfer_sel | input | 2 | Stored slot chosen for a transfer |
| step_arm | input | 1 | Single-cycle strobe that arms stepping |
| txn_end | input | 1 | End of transaction; disarms stepping |
| ser_clk | input | 1 | Serial clock, already in this clock domain |
| ser_din | input | 1 | Serial data line; gives the step direction |
| pos | output | 8 | Current wiper position |
| tap_sel | output | 256 | One-hot tap select, one cycle behind `pos` |

## Verification
The bench drives the register up to 0xFF and down to 0x00 with extra steps in the same direction. A design whose counter wraps would jump to the opposite end of the array. It holds `ser_clk` high for several cycles to catch a level-sensitive stepper that keeps moving. It sends clock pulses after `txn_end`, in the same cycle as `txn_end`, and after a reset in the middle of a run, to catch a step window that stays open when it should be closed. It also puts writes, transfers and steps in the same cycle, and it samples `tap_sel` both before and after its one-cycle lag, which catches a decoder that is combinational or off by a cycle.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RECALL,
        SRC_WRITE,
        SRC_XFER,
        SRC_STEP
    } load_src_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_req_t;

endpackage

// File: rtl/wpr_edge_detect.sv
module wpr_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b1;
        else     sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/wpr_step_ctrl.sv
module wpr_step_ctrl
    import wpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm_i,
    input  logic      end_i,
    input  logic      rise_i,
    input  logic      din_i,
    output step_req_t req_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)        armed_q <= 1'b0;
        else if (end_i) armed_q <= 1'b0;
        else if (arm_i) armed_q <= 1'b1;
    end

    assign req_o.valid = armed_q & rise_i & ~end_i;
    assign req_o.up    = din_i;
endmodule

// File: rtl/wpr_load_sel.sv
module wpr_load_sel
    import wpr_pkg::*;
#(
    parameter int POS_W     = 8,
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
    input  logic                       rst,
    input  logic [NUM_SLOTS*POS_W-1:0] bank,
    input  logic                       wr_stb,
    input  logic [POS_W-1:0]           wr_data,
    input  logic                       xfer_stb,
    input  logic [SEL_W-1:0]           xfer_sel,
    input  step_req_t                  step,
    input  logic [POS_W-1:0]           pos_q,
    output logic [POS_W-1:0]           pos_d
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] POS_MIN = '0;

    logic [POS_W-1:0] slot [NUM_SLOTS];
    load_src_e        src;
    logic [POS_W-1:0] stepped;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot[s] = bank[s*POS_W +: POS_W];
    end

    always_comb begin
        if (rst)             src = SRC_RECALL;
        else if (wr_stb)     src = SRC_WRITE;
        else if (xfer_stb)   src = SRC_XFER;
        else if (step.valid) src = SRC_STEP;
        else                 src = SRC_HOLD;
    end

    always_comb begin
        if (step.up) stepped = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
        else         stepped = (pos_q == POS_MIN) ? pos_q : pos_q - 1'b1;
    end

    always_comb begin
        case (src)
            SRC_RECALL: pos_d = slot[0];
            SRC_WRITE:  pos_d = wr_data;
            SRC_XFER:   pos_d = slot[xfer_sel];
            SRC_STEP:   pos_d = stepped;
            default:    pos_d = pos_q;
        endcase
    end
endmodule

// File: rtl/wpr_tap_decode.sv
module wpr_tap_decode #(
    parameter int POS_W = 8,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] recall_i,
    output logic [TAPS-1:0]  tap_o
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) tap_o[t] <= (recall_i == POS_W'(t));
            else     tap_o[t] <= (pos_i == POS_W'(t));
        end
    end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wpr_pkg::*;
#(
    parameter int POS_W     = 8,
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int TAPS     = 1 << POS_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SLOTS*POS_W-1:0] bank,
    input  logic                       wr_stb,
    input  logic [POS_W-1:0]           wr_data,
    input  logic                       xfer_stb,
    input  logic [SEL_W-1:0]           xfer_sel,
    input  logic                       step_arm,
    input  logic                       txn_end,
    input  logic                       ser_clk,
    input  logic                       ser_din,
    output logic [POS_W-1:0]           pos,
    output logic [TAPS-1:0]            tap_sel
);
    logic             sclk_rise;
    step_req_t        step;
    logic [POS_W-1:0] pos_d;

    wpr_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (ser_clk),
        .rise_o (sclk_rise)
    );

    wpr_step_ctrl u_step (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (step_arm),
        .end_i  (txn_end),
        .rise_i (sclk_rise),
        .din_i  (ser_din),
        .req_o  (step)
    );

    wpr_load_sel #(.POS_W(POS_W), .NUM_SLOTS(NUM_SLOTS)) u_sel (
        .rst      (rst),
        .bank     (bank),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .xfer_stb (xfer_stb),
        .xfer_sel (xfer_sel),
        .step     (step),
        .pos_q    (pos),
        .pos_d    (pos_d)
    );

    always_ff @(posedge clk) begin
        pos <= pos_d;
    end

    wpr_tap_decode #(.POS_W(POS_W)) u_tap (
        .clk      (clk),
        .rst      (rst),
        .pos_i    (pos),
        .recall_i (bank[POS_W-1:0]),
        .tap_o    (tap_sel)
    );
endmodule

// File: rtl/wiper_pos_reg_chk.sv
module wiper_pos_reg_chk #(
    parameter int POS_W     = 8,
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int TAPS     = 1 << POS_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_SLOTS*POS_W-1:0] bank,
    input logic                       wr_stb,
    input logic [POS_W-1:0]           wr_data,
    input logic                       xfer_stb,
    input logic [SEL_W-1:0]           xfer_sel,
    input logic [POS_W-1:0]           pos,
    input logic [TAPS-1:0]            tap_sel
);
    localparam logic [TAPS-1:0]  ONE_HOT0 = TAPS'(1);
    localparam logic [POS_W-1:0] TOP      = '1;

    logic past_ok;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_recall_R1: assert property (@(posedge clk)
        past_ok && $past(rst) |-> pos == $past(bank[POS_W-1:0]));

    assert_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> pos == $past(wr_data));

    assert_xfer_R3: assert property (@(posedge clk) disable iff (rst)
        xfer_stb && !wr_stb |=> pos == $past(bank[xfer_sel*POS_W +: POS_W]));

    assert_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_stb && !xfer_stb |=>
        (pos == $past(pos) || pos == $past(pos) + 1'b1 || pos == $past(pos) - 1'b1));

    assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_stb && !xfer_stb && pos == TOP |=> pos != '0);

    assert_no_wrap_bottom_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_stb && !xfer_stb && pos == '0 |=> pos != TOP);

    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> $countones(tap_sel) == 1);

    assert_tap_lag_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(rst) |-> tap_sel == (ONE_HOT0 << $past(pos)));
endmodule

bind wiper_pos_reg wiper_pos_reg_chk #(.POS_W(POS_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bank     (bank),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .xfer_stb (xfer_stb),
    .xfer_sel (xfer_sel),
    .pos      (pos),
    .tap_sel  (tap_sel)
);

// File: tb/sim_wiper_pos_reg.sv
`timescale 1ns/1ps
module sim_wiper_pos_reg;
    logic         clk = 1'b0;
    logic         rst;
    logic [31:0]  bank;
    logic         wr_stb;
    logic [7:0]   wr_data;
    logic         xfer_stb;
    logic [1:0]   xfer_sel;
    logic         step_arm;
    logic         txn_end;
    logic         ser_clk;
    logic         ser_din;
    logic [7:0]   pos;
    logic [255:0] tap_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    wiper_pos_reg u0 (
        .clk(clk), .rst(rst), .bank(bank), .wr_stb(wr_stb), .wr_data(wr_data),
        .xfer_stb(xfer_stb), .xfer_sel(xfer_sel), .step_arm(step_arm),
        .txn_end(txn_end), .ser_clk(ser_clk), .ser_din(ser_din),
        .pos(pos), .tap_sel(tap_sel)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_pos(input string req, input logic [7:0] exp);
        check(pos === exp, req, int'(pos), int'(exp));
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_stb = 1'b1; wr_data = d; tick(); wr_stb = 1'b0;
    endtask

    task automatic pulse(input bit up);
        ser_din = up; ser_clk = 1'b1; tick(); ser_clk = 1'b0; tick();
    endtask

    task automatic arm();
        step_arm = 1'b1; tick(); step_arm = 1'b0;
    endtask

    task automatic t_reset();
        bank = {8'h11, 8'h22, 8'h99, 8'h37};
        rst = 1'b1; tick(); tick(); tick();
        check_pos("R1 during reset", 8'h37);
        rst = 1'b0; tick();
        check_pos("R1 after release", 8'h37);
        check(tap_sel[8'h37] === 1'b1 && $countones(tap_sel) == 1, "R8 reset tap",
              $countones(tap_sel), 1);
    endtask

    task automatic t_write();
        do_write(8'h5A);
        check_pos("R2 write 5A", 8'h5A);
        check(tap_sel[8'h5A] === 1'b0, "R8 tap lag before", int'(tap_sel[8'h5A]), 0);
        tick();
        check(tap_sel[8'h5A] === 1'b1 && $countones(tap_sel) == 1, "R8 tap after lag",
              int'(tap_sel[8'h5A]), 1);
        do_write(8'h00); tick();
        check_pos("R2 write 00", 8'h00);
        check(tap_sel[0] === 1'b1, "R8 low end tap", int'(tap_sel[0]), 1);
        do_write(8'hFF); tick();
        check_pos("R2 write FF", 8'hFF);
        check(tap_sel[255] === 1'b1, "R8 high end tap", int'(tap_sel[255]), 1);
    endtask

    task automatic t_xfer();
        for (int s = 0; s < 4; s++) begin
            xfer_sel = 2'(s); xfer_stb = 1'b1; tick(); xfer_stb = 1'b0;
            check_pos("R3 transfer", bank[s*8 +: 8]);
        end
    endtask

    task automatic t_priority();
        wr_data = 8'hA5; wr_stb = 1'b1; xfer_stb = 1'b1; xfer_sel = 2'd3; tick();
        wr_stb = 1'b0; xfer_stb = 1'b0;
        check_pos("R4 write over transfer", 8'hA5);
        arm();
        ser_din = 1'b1; ser_clk = 1'b1; xfer_stb = 1'b1; xfer_sel = 2'd2; tick();
        xfer_stb = 1'b0; ser_clk = 1'b0; tick();
        check_pos("R4 transfer over step", 8'h22);
        txn_end = 1'b1; tick(); txn_end = 1'b0;
    endtask

    task automatic t_step();
        do_write(8'h80); arm();
        for (int i = 0; i < 3; i++) pulse(1'b1);
        check_pos("R5 three up steps", 8'h83);
        for (int i = 0; i < 5; i++) pulse(1'b0);
        check_pos("R5 five down steps", 8'h7E);
        ser_din = 1'b1; ser_clk = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        ser_clk = 1'b0; tick();
        check_pos("R5 held clock one step", 8'h7F);
    endtask

    task automatic t_saturate();
        do_write(8'hFE);
        for (int i = 0; i < 3; i++) pulse(1'b1);
        check_pos("R6 saturate high", 8'hFF);
        do_write(8'h01);
        for (int i = 0; i < 3; i++) pulse(1'b0);
        check_pos("R6 saturate low", 8'h00);
    endtask

    task automatic t_window();
        do_write(8'h40);
        txn_end = 1'b1; tick(); txn_end = 1'b0;
        pulse(1'b1); pulse(1'b1);
        check_pos("R7 disarmed after end", 8'h40);
        arm();
        ser_din = 1'b1; ser_clk = 1'b1; txn_end = 1'b1; tick();
        ser_clk = 1'b0; txn_end = 1'b0; tick();
        check_pos("R7 edge with end ignored", 8'h40);
        arm(); pulse(1'b0);
        check_pos("R7 rearmed step", 8'h3F);
        bank[7:0] = 8'hC4;
        rst = 1'b1; tick(); rst = 1'b0;
        check_pos("R1 recall mid run", 8'hC4);
        pulse(1'b1);
        check_pos("R7 reset disarms", 8'hC4);
    endtask

    initial begin
        #(20 * 60000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bank = '0; wr_stb = 1'b0; wr_data = '0; xfer_stb = 1'b0;
        xfer_sel = '0; step_arm = 1'b0; txn_end = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_xfer();
        t_priority();
        t_step();
        t_saturate();
        t_window();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule